// File: doc/BRIEF.md
# Suspend Event SMI Delay Timer

This block postpones a system management interrupt request after one of two power events: a press of the suspend/resume button or a battery-low warning. Both event lines are active low and synchronous to the block clock. A falling edge on an enabled line starts one shared countdown. The countdown is loaded from an 8-bit programmable count. It advances only on a one-cycle tick strobe that comes from outside; a 128 ms tick gives delays from 128 ms to about 32 s. When the count runs out, the block raises a one-cycle SMI request and sets a sticky status bit for each source that started that delay.

The battery-low line can be set to skip the countdown. In that mode its falling edge raises the SMI request on the next cycle, and any countdown already in progress carries on unchanged. Software programs the count, the enables and the bypass through a simple write port. Status is cleared by writing ones to it.

Top module: `smi_delay_timer`

## Requirements
- R1: After reset, smi_o is 0 and sts_o is 0. The count register is 00h and the control bits (button enable, battery enable, bypass) are all 0.
- R2: While the count register holds 00h, no delay starts. An enabled delayed trigger is then dropped, and no SMI or status follows it.
- R3: A falling edge on a source has no effect unless that source's enable bit is 1. The enable bits are control bit 0 for the button and control bit 1 for battery-low.
- R4: A delay starts at the clock edge that first samples an enabled source low. From there:
  - The tick sampled at that same edge is not counted.
  - smi_o is high for exactly the one cycle after the edge that samples the N-th later tick, where N is the count loaded at start.
- R5: When control bit 2 (bypass) and the battery enable are both 1, a battery-low falling edge drives smi_o high in the next cycle and sets sts_o[1]. This happens whatever the count value, and it leaves a running delay untouched.
- R6: Only a high-to-low transition triggers. A line held low triggers at most once; it must go high again before it can trigger another delay.
- R7: A trigger that arrives while a delay is running is ignored. It neither restarts the countdown nor adds its source to the status of that delay.
- R8: On expiry the block sets sts_o bit 0 (button) and/or bit 1 (battery-low) for the sources that started the delay. Writing address 2 clears each status bit whose data bit is 1. A set and a clear on the same edge leave the bit set.
- R9: A write to the count register during a running delay does not change that delay; the new value applies from the next start.
- R10: The write port decodes address 0 as the count, address 1 as the control bits [2:0] and address 2 as the status clear. A write to address 3 changes nothing.
- R11: Enabled delayed triggers from both sources on the same edge start one delay. Its expiry gives a single SMI pulse with both status bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle time base strobe |
| btn_ni | input | 1 | Suspend/resume button event, active low |
| batlow_ni | input | 1 | Battery-low event, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| smi_o | output | 1 | One-cycle SMI request pulse |
| sts_o | output | 2 | Sticky source status: bit 0 button, bit 1 battery-low |

## Verification
The bench targets the cycle boundaries of the countdown. One test lines up a tick with the start edge; a design that counted that tick would fire one tick early. Other tests rewrite the count mid-delay and hit a running delay with a second trigger. A design that reloads the counter live would fire at the new value, and one that restarts on a retrigger would fire late or add the wrong status bit. Further tests hold a line low across many ticks, fire the bypass in the middle of a delay, and land a status clear on the expiry edge. These catch level-triggered repeats, a bypass that kills the pending delay, and a clear that wins over a new set. A random phase then compares every cycle against a bench model built from the requirements.

// File: rtl/smi_dly_pkg.sv
package smi_dly_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CNT = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTL = 2'd1;
  localparam logic [ADDR_W-1:0] A_STS = 2'd2;

  localparam int unsigned NSRC    = 2;
  localparam int unsigned SRC_BTN = 0;
  localparam int unsigned SRC_BAT = 1;

  localparam int unsigned CTL_W      = 3;
  localparam int unsigned CTL_BTN_EN = 0;
  localparam int unsigned CTL_BAT_EN = 1;
  localparam int unsigned CTL_BYP    = 2;
endpackage

// File: rtl/smi_dly_edge.sv
module smi_dly_edge #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_ni,
  output logic [W-1:0] fall_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b1;
      else         prev_q <= in_ni[i];
    end
    assign fall_o[i] = prev_q & ~in_ni[i];

    // R6
    one_shot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_o[i] |=> !fall_o[i]);
  end
endmodule

// File: rtl/smi_dly_regs.sv
module smi_dly_regs
  import smi_dly_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] cnt_cfg_o,
  output logic [CTL_W-1:0]  ctl_o,
  output logic [NSRC-1:0]   clr_o
);
  logic [DATA_W-1:0] cnt_q;
  logic [CTL_W-1:0]  ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ctl_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_CNT) cnt_q <= wr_data_i;
      if (wr_addr_i == A_CTL) ctl_q <= wr_data_i[CTL_W-1:0];
    end
  end

  assign cnt_cfg_o = cnt_q;
  assign ctl_o     = ctl_q;
  assign clr_o     = (wr_en_i && wr_addr_i == A_STS) ? wr_data_i[NSRC-1:0] : '0;

  // R10
  ctl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != A_CTL) |=> $stable(ctl_o));
endmodule

// File: rtl/smi_dly_core.sv
module smi_dly_core #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned NSRC  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [NSRC-1:0]  req_i,
  input  logic [CNT_W-1:0] cfg_cnt_i,
  output logic             expire_o,
  output logic [NSRC-1:0]  src_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [NSRC-1:0]  src_q;
  logic             start, last;

  assign start = !run_q && (|req_i) && (cfg_cnt_i != '0);
  assign last  = run_q && tick_i && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      src_q <= '0;
    end else if (run_q) begin
      if (tick_i) begin
        if (cnt_q == ONE) run_q <= 1'b0;
        else              cnt_q <= cnt_q - ONE;
      end
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= cfg_cnt_i;
      src_q <= req_i;
    end
  end

  assign expire_o = last;
  assign src_o    = src_q;

  // R2
  no_zero_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> cnt_q != '0);
  // R7
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !tick_i) |=> (run_q && $stable(cnt_q) && $stable(src_q)));
  // R4
  expire_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !run_q);
endmodule

// File: rtl/smi_delay_timer.sv
module smi_delay_timer
  import smi_dly_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              btn_ni,
  input  logic              batlow_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic              smi_o,
  output logic [NSRC-1:0]   sts_o
);
  logic [NSRC-1:0]  fall, req, clr, src, set_mask;
  logic [CTL_W-1:0] ctl;
  logic [CNT_W-1:0] cnt_cfg;
  logic             expire, bat_trig, bat_byp;
  logic             smi_q;
  logic [NSRC-1:0]  sts_q;

  smi_dly_edge #(.W(NSRC)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_ni ({batlow_ni, btn_ni}),
    .fall_o(fall)
  );

  smi_dly_regs #(.DATA_W(CNT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .cnt_cfg_o(cnt_cfg),
    .ctl_o    (ctl),
    .clr_o    (clr)
  );

  assign bat_trig     = fall[SRC_BAT] & ctl[CTL_BAT_EN];
  assign bat_byp      = bat_trig & ctl[CTL_BYP];
  assign req[SRC_BTN] = fall[SRC_BTN] & ctl[CTL_BTN_EN];
  assign req[SRC_BAT] = bat_trig & ~ctl[CTL_BYP];

  smi_dly_core #(.CNT_W(CNT_W), .NSRC(NSRC)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .req_i    (req),
    .cfg_cnt_i(cnt_cfg),
    .expire_o (expire),
    .src_o    (src)
  );

  always_comb begin
    set_mask          = expire ? src : '0;
    set_mask[SRC_BAT] = set_mask[SRC_BAT] | bat_byp;
  end

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smi_q <= 1'b0;
      sts_q <= '0;
    end else begin
      smi_q <= |set_mask;
      sts_q <= (sts_q & ~clr) | set_mask;
    end
  end

  assign smi_o = smi_q;
  assign sts_o = sts_q;

  // R4
  expire_smi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> smi_o);
  // R5
  bypass_smi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bat_byp |=> (smi_o && sts_o[SRC_BAT]));
  // R8
  smi_has_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o |-> sts_o != '0);
  // R3
  gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl == '0) |-> req == '0);
endmodule

// File: tb/smi_delay_timer_tb.sv
module smi_delay_timer_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0, btn_ni = 1'b1, batlow_ni = 1'b1;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       smi_o;
  logic [1:0] sts_o;

  int n_chk = 0, n_fail = 0, smi_cnt = 0;
  bit cmp_en = 1'b0, done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  smi_delay_timer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .btn_ni(btn_ni),
    .batlow_ni(batlow_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .smi_o(smi_o), .sts_o(sts_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model built from the requirements
  logic [7:0] m_creg, m_cnt;
  logic [2:0] m_ctl;
  logic [1:0] m_sts, m_src;
  logic       m_run, m_smi, m_bq, m_aq;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_creg = 0; m_cnt = 0; m_ctl = 0; m_sts = 0; m_src = 0;
      m_run = 0; m_smi = 0; m_bq = 1; m_aq = 1;
    end else begin
      logic fb, fa, tb, ta, byp, da;
      logic [1:0] set, clr;
      fb = m_bq & ~btn_ni; fa = m_aq & ~batlow_ni;
      m_bq = btn_ni; m_aq = batlow_ni;
      tb = fb & m_ctl[0]; ta = fa & m_ctl[1];
      byp = ta & m_ctl[2]; da = ta & ~m_ctl[2];
      set = 0;
      if (m_run) begin
        if (tick_i) begin
          if (m_cnt == 1) begin set = m_src; m_run = 0; end
          else m_cnt = m_cnt - 1;
        end
      end else if ((tb | da) && m_creg != 0) begin
        m_run = 1; m_cnt = m_creg; m_src = {da, tb};
      end
      set[1] = set[1] | byp;
      clr = (wr_en_i && wr_addr_i == 2) ? wr_data_i[1:0] : 2'b00;
      m_sts = (m_sts & ~clr) | set;
      m_smi = |set;
      if (wr_en_i && wr_addr_i == 0) m_creg = wr_data_i;
      if (wr_en_i && wr_addr_i == 1) m_ctl = wr_data_i[2:0];
    end
  end

  always @(negedge clk_i) begin
    if (smi_o) smi_cnt++;
    if (rst_ni && cmp_en) begin
      chk("R4 model smi", smi_o, m_smi);
      chk("R8 model sts", sts_o, m_sts);
    end
  end

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 0;
  endtask
  task automatic tk(input int n = 1);
    for (int i = 0; i < n; i++) begin
      tick_i = 1; @(negedge clk_i); tick_i = 0;
    end
  endtask

  initial begin
    int base;
    void'($urandom(32'h1d5e));
    cyc(3);
    rst_ni = 1;
    cmp_en = 1;
    cyc(1);
    // R1 reset state
    chk("R1 smi", smi_o, 0);
    chk("R1 sts", sts_o, 0);

    // R2: count still 00h, enables on
    wr(1, 8'h03);
    base = smi_cnt;
    btn_ni = 0; cyc(1); tk(10); cyc(2);
    chk("R2 no smi at count 0", smi_cnt - base, 0);
    chk("R2 sts", sts_o, 0);
    btn_ni = 1; cyc(1);

    // R4: tick on the start edge is not counted
    wr(0, 8'd3);
    btn_ni = 0; tick_i = 1; cyc(1); tick_i = 0;
    tk(2);
    chk("R4 early", smi_o, 0);
    tk(1);
    chk("R4 fire", smi_o, 1);
    chk("R8 btn sts", sts_o, 1);
    cyc(1);
    chk("R4 single pulse", smi_o, 0);

    // R8 clear
    wr(2, 8'h01);
    chk("R8 w1c", sts_o, 0);

    // R6 held low
    base = smi_cnt;
    tk(6); cyc(2);
    chk("R6 held low", smi_cnt - base, 0);
    btn_ni = 1; cyc(1); btn_ni = 0; cyc(1); tk(3);
    chk("R6 re-arm", smi_o, 1);
    btn_ni = 1; wr(2, 8'h03);

    // R3 battery disabled
    wr(1, 8'h01);
    base = smi_cnt;
    batlow_ni = 0; cyc(1); tk(5); cyc(2);
    chk("R3 gated smi", smi_cnt - base, 0);
    chk("R3 gated sts", sts_o, 0);
    batlow_ni = 1; cyc(1);

    // R5 bypass during a running delay
    wr(1, 8'h07);
    btn_ni = 0; cyc(1); tk(1);
    batlow_ni = 0; cyc(1);
    chk("R5 bypass smi", smi_o, 1);
    chk("R5 bypass sts", sts_o, 2);
    tk(1);
    chk("R5 delay kept early", smi_o, 0);
    tk(1);
    chk("R5 delay kept fire", smi_o, 1);
    chk("R5 sts both", sts_o, 3);
    btn_ni = 1; batlow_ni = 1; wr(2, 8'h03);
    // R5 bypass with count 00h
    wr(0, 8'd0);
    batlow_ni = 0; cyc(1);
    chk("R5 bypass count0", smi_o, 1);
    batlow_ni = 1; wr(2, 8'h03);

    // R7 retrigger ignored
    wr(1, 8'h03); wr(0, 8'd4);
    base = smi_cnt;
    btn_ni = 0; cyc(1); tk(2);
    batlow_ni = 0; cyc(1); tk(1);
    chk("R7 no early", smi_o, 0);
    tk(1);
    chk("R7 fire on time", smi_o, 1);
    chk("R7 sts btn only", sts_o, 1);
    tk(5); cyc(1);
    chk("R7 one smi", smi_cnt - base, 1);
    btn_ni = 1; batlow_ni = 1; wr(2, 8'h03);

    // R9 count rewrite mid-delay
    btn_ni = 0; cyc(1); tk(1);
    wr(0, 8'd1);
    tk(2);
    chk("R9 not reloaded", smi_o, 0);
    tk(1);
    chk("R9 fire at old count", smi_o, 1);
    btn_ni = 1; wr(2, 8'h03);

    // R10 address 3 ignored
    wr(0, 8'd2);
    wr(3, 8'h00);
    btn_ni = 0; cyc(1); tk(2);
    chk("R10 addr3 ignored", smi_o, 1);
    btn_ni = 1; wr(2, 8'h03);

    // R11 both sources together
    base = smi_cnt;
    btn_ni = 0; batlow_ni = 0; cyc(1); tk(2);
    chk("R11 sts both", sts_o, 3);
    cyc(2);
    chk("R11 one pulse", smi_cnt - base, 1);
    btn_ni = 1; batlow_ni = 1; wr(2, 8'h03);

    // R8 set wins over same-edge clear
    wr(0, 8'd1);
    btn_ni = 0; cyc(1);
    tick_i = 1; wr_en_i = 1; wr_addr_i = 2; wr_data_i = 8'h01;
    cyc(1);
    tick_i = 0; wr_en_i = 0;
    chk("R8 set beats clear", sts_o, 1);
    btn_ni = 1; wr(2, 8'h03);

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 8 == 0) btn_ni = ~btn_ni;
      if ($urandom % 9 == 0) batlow_ni = ~batlow_ni;
      tick_i = ($urandom % 3 == 0);
      wr_en_i = ($urandom % 12 == 0);
      wr_addr_i = 2'($urandom % 4);
      wr_data_i = (wr_addr_i == 0) ? 8'($urandom % 6) : 8'($urandom);
      cyc(1);
    end
    wr_en_i = 0; tick_i = 0;
    cyc(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule